// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a watchdog timer that software controls by writing 16-bit magic words to a key register. One word opens write access to the divider-select and reload registers. A second word starts the count, and once started the count cannot be stopped except by the block reset. A third word refreshes the down-counter. A separate `tick` input stands in for a slow free-running clock. A prescaler divides that tick, and a 12-bit down-counter steps on each divided tick. When the counter passes zero, the block pulses a reset request for one cycle and reloads the counter.

New prescaler or reload settings are not used at once. Each written value waits a fixed number of ticks before the counting logic takes it. During that wait, a pending flag in the status register stays high. The register interface is a plain valid/write strobe with a word-aligned address and a combinational read path.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `rst_req` is 0, the status register (offset 0x0C) reads 0, the prescaler register (offset 0x04) reads 0, the reload register (offset 0x08) reads 0xFFF, and the watchdog is stopped.
- R2: Key writes go to offset 0x00, and only `wdata[15:0]` is compared. The word 0x5555 opens write access. Any other key word closes write access again.
- R3: While write access is closed, writes to the prescaler register (bits 2:0) and the reload register (bits 11:0) leave the stored value and the status register unchanged.
- R4: An accepted prescaler write sets status bit 0, and an accepted reload write sets status bit 1. Each bit clears on the second `tick` after the write. Only then does the counting logic use the new value.
- R5: Prescaler code c divides the tick by 4·2^c for c = 0 to 6. Code 7 divides by 256, the same as code 6.
- R6: After the start word 0xCCCC, with reload value N and divider D, `rst_req` pulses after the (N+1)·D-th tick.
- R7: The refresh word 0xAAAA reloads the counter from the reload value and clears the prescaler phase, so a full timeout counts again from that write.
- R8: After an expiry, the counter reloads by itself, and further expiries follow at the same period.
- R9: Software cannot stop a running watchdog: no key word stops it. Only `rst_n` returns the block to the stopped state. While stopped, ticks never raise `rst_req`.
- R10: `rst_req` is high for exactly one clock cycle per expiry, and only while the watchdog runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits 3:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick | input | 1 | One-cycle pulse from the slow count clock |
| rst_req | output | 1 | One-cycle system reset request on expiry |

## Verification
The hardest state to reach is an expiry that follows a refresh or a second timeout period. Reaching it needs several hundred ticks applied with exact counting after a fully staged configuration: unlock, write, wait for the pending flags to clear, then start. The bench drives the tick one pulse at a time, and for each pulse it predicts whether a reset request must appear. Random divider codes and reload values, including the two codes that both mean divide-by-256, are run over two periods each. Directed cases cover refresh in mid-count, attempts to stop or restart the running count, and writes while write access is closed.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int CNT_W      = 12,
  parameter int PRE_W      = 3,
  parameter int MAX_SHIFT  = 6,
  parameter int SYNC_TICKS = 2,
  parameter logic [15:0] KEY_OPEN  = 16'h5555,
  parameter logic [15:0] KEY_START = 16'hCCCC,
  parameter logic [15:0] KEY_FEED  = 16'hAAAA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        tick,
  output logic        rst_req
);
  localparam int DIV_W = MAX_SHIFT + 2;
  localparam int PC_W  = $clog2(SYNC_TICKS + 1);

  logic             unlocked, running;
  logic [PRE_W-1:0] pre_reg, pre_act;
  logic [CNT_W-1:0] rld_reg, rld_act, cnt;
  logic             pre_pend, rld_pend;
  logic [PC_W-1:0]  pre_pc, rld_pc;
  logic [DIV_W-1:0] div, div_lim;
  int               shift;

  wire        acc    = bus_valid & bus_write;
  wire [15:0] key    = bus_wdata[15:0];
  wire        key_wr = acc && bus_addr[3:2] == 2'd0;
  wire        pre_wr = acc && bus_addr[3:2] == 2'd1 && unlocked;
  wire        rld_wr = acc && bus_addr[3:2] == 2'd2 && unlocked;

  assign shift   = (int'(pre_act) > MAX_SHIFT) ? MAX_SHIFT : int'(pre_act);
  assign div_lim = ~({DIV_W{1'b1}} << (shift + 2));

  always_comb begin
    case (bus_addr[3:2])
      2'd1:    bus_rdata = 32'(pre_reg);
      2'd2:    bus_rdata = 32'(rld_reg);
      2'd3:    bus_rdata = {30'd0, rld_pend, pre_pend};
      default: bus_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      unlocked <= 1'b0;
    else if (key_wr) unlocked <= (key == KEY_OPEN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_reg <= '0; pre_act <= '0; pre_pend <= 1'b0; pre_pc <= '0;
    end else if (pre_wr) begin
      pre_reg <= bus_wdata[PRE_W-1:0]; pre_pend <= 1'b1; pre_pc <= '0;
    end else if (tick && pre_pend) begin
      if (pre_pc == PC_W'(SYNC_TICKS - 1)) begin
        pre_pend <= 1'b0; pre_act <= pre_reg;
      end else pre_pc <= pre_pc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld_reg <= '1; rld_act <= '1; rld_pend <= 1'b0; rld_pc <= '0;
    end else if (rld_wr) begin
      rld_reg <= bus_wdata[CNT_W-1:0]; rld_pend <= 1'b1; rld_pc <= '0;
    end else if (tick && rld_pend) begin
      if (rld_pc == PC_W'(SYNC_TICKS - 1)) begin
        rld_pend <= 1'b0; rld_act <= rld_reg;
      end else rld_pc <= rld_pc + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0; cnt <= '1; div <= '0; rst_req <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (key_wr && key == KEY_START && !running) begin
        running <= 1'b1; cnt <= rld_act; div <= '0;
      end else if (key_wr && key == KEY_FEED) begin
        cnt <= rld_act; div <= '0;
      end else if (running && tick) begin
        if (div >= div_lim) begin
          div <= '0;
          if (cnt == '0) begin
            rst_req <= 1'b1; cnt <= rld_act;
          end else cnt <= cnt - 1'b1;
        end else div <= div + 1'b1;
      end
    end
  end
endmodule

// File: rtl/keyed_watchdog_checker.sv
module keyed_watchdog_checker #(
  parameter int CNT_W = 12,
  parameter int PRE_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_write,
  input logic [3:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             rst_req,
  input logic             running,
  input logic             unlocked,
  input logic [PRE_W-1:0] pre_reg,
  input logic [CNT_W-1:0] rld_reg
);
  wire acc = bus_valid && bus_write;

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  a_r10_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> running);

  a_r9_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);

  a_r2_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bus_addr[3:2] == 2'd0 && bus_wdata[15:0] != 16'h5555) |=> !unlocked);

  a_r3_locked_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bus_addr[3:2] == 2'd1 && !unlocked) |=> $stable(pre_reg));

  a_r3_locked_rld: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bus_addr[3:2] == 2'd2 && !unlocked) |=> $stable(rld_reg));

  a_r4_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && bus_addr[3:2] == 2'd1 && unlocked) |=> (bus_addr[3:2] != 2'd3 || bus_rdata[0]));
endmodule

bind keyed_watchdog keyed_watchdog_checker #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .rst_req(rst_req), .running(running), .unlocked(unlocked),
  .pre_reg(pre_reg), .rld_reg(rld_reg)
);

// File: tb/keyed_watchdog_bench.sv
`timescale 1ns/1ps
module keyed_watchdog_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0, tick = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rst_req;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  keyed_watchdog u_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick(tick), .rst_req(rst_req)
  );

  function automatic int period(input int code, input int n);
    int sh = (code > 6) ? 6 : code;
    return (n + 1) * (4 << sh);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic do_tick(output logic got);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    got = rst_req;
  endtask

  task automatic configure(input int code, input int n);
    logic g;
    do_reset();
    wr(4'h0, 32'h5555);
    wr(4'h4, 32'(code));
    wr(4'h8, 32'(n));
    repeat (2) do_tick(g);
  endtask

  task automatic run_ticks(input string req, input int total, input int per);
    logic g;
    for (int i = 1; i <= total; i++) begin
      do_tick(g);
      chk(req, g, (i % per) == 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R0 watchdog expired actual=hang expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic g;
    void'($urandom(32'd4711));
    do_reset();
    chk("R1 rst_req", rst_req, 0);
    rd(4'hC, d); chk("R1 status", d, 0);
    rd(4'h4, d); chk("R1 prescaler", d, 0);
    rd(4'h8, d); chk("R1 reload", d, 32'hFFF);
    run_ticks("R9 stopped after reset", 20, 1 << 30);

    wr(4'h4, 32'd5); wr(4'h8, 32'd9);
    rd(4'h4, d); chk("R3 locked prescaler", d, 0);
    rd(4'h8, d); chk("R3 locked reload", d, 32'hFFF);
    rd(4'hC, d); chk("R3 locked status", d, 0);
    wr(4'h0, 32'h5555); wr(4'h0, 32'hAAAA); wr(4'h8, 32'd9);
    rd(4'h8, d); chk("R2 relock by other key", d, 32'hFFF);
    wr(4'h0, 32'hFFFF_5555); wr(4'h8, 32'd9);
    rd(4'h8, d); chk("R2 low half compared", d, 32'd9);
    repeat (2) do_tick(g);

    wr(4'h0, 32'h5555);
    wr(4'h4, 32'd3);
    rd(4'hC, d); chk("R4 pre pending set", d, 1);
    do_tick(g); rd(4'hC, d); chk("R4 pre pending after 1 tick", d, 1);
    do_tick(g); rd(4'hC, d); chk("R4 pre pending cleared", d, 0);
    wr(4'h8, 32'd7);
    rd(4'hC, d); chk("R4 rld pending set", d, 2);
    do_tick(g); rd(4'hC, d); chk("R4 rld pending after 1 tick", d, 2);
    do_tick(g); rd(4'hC, d); chk("R4 rld pending cleared", d, 0);
    rd(4'h4, d); chk("R4 prescaler value", d, 3);

    configure(0, 2);
    run_ticks("R9 configured but not started", 30, 1 << 30);
    wr(4'h0, 32'hCCCC);
    run_ticks("R6 R8 code0 n2", 2 * period(0, 2), period(0, 2));

    configure(0, 3);
    wr(4'h0, 32'hCCCC);
    run_ticks("R7 before refresh", 10, 1 << 30);
    wr(4'h0, 32'hAAAA);
    run_ticks("R7 after refresh", period(0, 3), period(0, 3));

    configure(1, 1);
    wr(4'h0, 32'hCCCC);
    run_ticks("R9 pre stop attempt", 5, 1 << 30);
    wr(4'h0, 32'h0000); wr(4'h0, 32'hCCCC); wr(4'h0, 32'h5555);
    run_ticks("R9 still running", period(1, 1) - 5, period(1, 1) - 5);

    configure(6, 0);
    wr(4'h0, 32'hCCCC);
    run_ticks("R5 code6", period(6, 0), period(6, 0));
    configure(7, 0);
    wr(4'h0, 32'hCCCC);
    run_ticks("R5 code7", period(7, 0), period(7, 0));

    for (int k = 0; k < 10; k++) begin
      int code = int'($urandom % 8);
      int n = int'($urandom % 4);
      configure(code, n);
      wr(4'h0, 32'hCCCC);
      run_ticks("R5 R6 R10 random", 2 * period(code, n), period(code, n));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule